// File: doc/BRIEF.md
# Floppy Drive Interface Status Registers

This block produces the two read-only status bytes that a PC-compatible floppy controller presents to software for drive-interface monitoring. It watches asynchronous drive pins (write protect, index, track zero, read data) and synchronous controller-side signals (direction, head, step, write gate, write data, motor enables, drive select, interrupt and DMA request), and formats them into register A and register B. The layout and polarity of both bytes depend on a mode selector: in PS/2 mode most bits are live levels and two bits toggle on data-line edges; in Model 30 mode polarities invert and several bits become sticky flags; in PC/AT mode neither byte is driven.

The sticky flags and toggles live in the block. A read of the digital input register (signalled by a one-clock strobe) clears the Model 30 flags, a software reset clears all flags and toggles, and a hardware reset clears everything including the motor-enable and drive-select copies. All drive-pin inputs are logically active high at the ports (1 means the condition is present). Register values are combinational from internal state; drive pins reach the output two clocks after they change, controller signals one clock after.

Top module: `fdc_drive_status`

## Requirements
- R1: When `mode_sel` is 2'b00 (PC/AT) or 2'b11 (reserved), `stat_oe` is 0 and both `stat_a` and `stat_b` read 8'h00; for 2'b01 (PS/2) and 2'b10 (Model 30) `stat_oe` is 1.
- R2: In PS/2 mode `stat_a` = {interrupt, 1, step level, NOT track0, head, NOT index, NOT write-protect, direction}, bit 7 first.
- R3: In Model 30 mode `stat_a` = {interrupt, DMA request, step flag, track0, NOT head, index, write-protect, NOT direction}, bit 7 first.
- R4: In PS/2 mode `stat_b` = {1, 1, drive-select bit 0, write-data toggle, read-data toggle, write gate level, motor 1, motor 0}, bit 7 first.
- R5: In Model 30 mode `stat_b` = {1, select≠1, select≠0, write-data flag, read-data flag, write-gate flag, 1, 1}, bit 7 first, where select is the 2-bit `drv_sel` value.
- R6: The step flag and write-gate flag set on the rising edge of their signals; the read-data and write-data flags set on the falling edge of theirs; a level held steady sets nothing.
- R7: The read-data and write-data toggles invert once per falling edge of their line and are not affected by `dir_rd`.
- R8: A `dir_rd` pulse clears the four Model 30 flags; when a flag's set edge falls in the same clock as `dir_rd`, the flag ends set.
- R9: `soft_rst` clears all flags and toggles but leaves motor-enable and drive-select status unchanged.
- R10: `rst` clears all flags, toggles, sampled pins and controller copies (motor-enable and drive-select included), so PS/2 reads give 8'h56 and 8'hC0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hardware reset, synchronous, active high |
| soft_rst | input | 1 | Software reset, one clock, active high |
| mode_sel | input | 2 | 00 PC/AT, 01 PS/2, 10 Model 30, 11 reserved |
| dir_rd | input | 1 | Strobe: digital input register is being read |
| ctl_dir | input | 1 | Head direction, 1 = inward |
| ctl_head | input | 1 | Head select, 1 = side 1 |
| ctl_step | input | 1 | Step output, 1 = active |
| ctl_wgate | input | 1 | Write gate, 1 = active |
| ctl_wdata | input | 1 | Write data line, 1 = active |
| irq_pend | input | 1 | Controller interrupt pending |
| dma_pend | input | 1 | DMA request pending |
| motor_en | input | 2 | Motor enables for drives 0 and 1 |
| drv_sel | input | 2 | Selected drive number |
| pin_wprot | input | 1 | Disk write protected (asynchronous) |
| pin_index | input | 1 | Index hole present (asynchronous) |
| pin_trk0 | input | 1 | Head at track zero (asynchronous) |
| pin_rdata | input | 1 | Read data line active (asynchronous) |
| stat_a | output | 8 | Register A read value |
| stat_b | output | 8 | Register B read value |
| stat_oe | output | 1 | Read data bus should be driven |

## Verification
The two functions that can collide are the edge-triggered setting of a sticky flag and the clearing read of the digital input register. The bench raises the step line and the `dir_rd` strobe on the same falling clock edge so both land on one rising edge, then reads register A in Model 30 mode and expects the step flag set; a follow-up `dir_rd` with step held high must clear it, showing that only an edge, not a level, re-arms the flag.

// File: rtl/fdcs_pkg.sv
package fdcs_pkg;

    typedef enum logic [1:0] {
        FMODE_AT  = 2'b00,
        FMODE_PS2 = 2'b01,
        FMODE_M30 = 2'b10,
        FMODE_RSV = 2'b11
    } fmode_e;

    localparam int SEL_W = 2;
    localparam int MTR_W = 2;

    // controller-side signals, synchronous to clk
    typedef struct packed {
        logic             dir;
        logic             head;
        logic             step;
        logic             wgate;
        logic             wdata;
        logic             irq;
        logic             dma;
        logic [MTR_W-1:0] mtr;
        logic [SEL_W-1:0] sel;
    } ctl_t;

    // asynchronous drive pins, asserted-high logical sense
    typedef struct packed {
        logic wp;
        logic index;
        logic trk0;
        logic rdata;
    } drv_t;

    localparam int DRV_W = $bits(drv_t);

    // edge-held state; bit 0 is step
    typedef struct packed {
        logic wd_tog;
        logic rd_tog;
        logic wdata;
        logic rdata;
        logic wgate;
        logic step;
    } lat_t;

    localparam int NEV = $bits(lat_t);
    localparam int EV_STEP   = 0;
    localparam int EV_WGATE  = 1;
    localparam int EV_RDATA  = 2;
    localparam int EV_WDATA  = 3;
    localparam int EV_RD_TOG = 4;
    localparam int EV_WD_TOG = 5;
    localparam logic [NEV-1:0] TOG_MASK = 6'b110000;

    function automatic logic [7:0] fmt_a_ps2(ctl_t c, drv_t d);
        return {c.irq, 1'b1, c.step, ~d.trk0, c.head, ~d.index, ~d.wp, c.dir};
    endfunction

    function automatic logic [7:0] fmt_a_m30(ctl_t c, drv_t d, lat_t l);
        return {c.irq, c.dma, l.step, d.trk0, ~c.head, d.index, d.wp, ~c.dir};
    endfunction

    function automatic logic [7:0] fmt_b_ps2(ctl_t c, lat_t l);
        return {2'b11, c.sel[0], l.wd_tog, l.rd_tog, c.wgate, c.mtr[1], c.mtr[0]};
    endfunction

    function automatic logic [7:0] fmt_b_m30(ctl_t c, lat_t l);
        return {1'b1, (c.sel != SEL_W'(1)), (c.sel != SEL_W'(0)),
                l.wdata, l.rdata, l.wgate, 2'b11};
    endfunction

endpackage

// File: rtl/fdcs_sync.sv
module fdcs_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/fdcs_event_cell.sv
module fdcs_event_cell #(
    parameter bit IS_TOGGLE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic soft_clr,
    input  logic rd_clr,
    input  logic evt,
    output logic q
);
    logic q_r;

    generate
        if (IS_TOGGLE) begin : g_tog
            always_ff @(posedge clk) begin
                if (rst || soft_clr) q_r <= 1'b0;
                else if (evt)        q_r <= ~q_r;
            end

            // R7
            toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
                (evt && !soft_clr) |=> (q_r != $past(q_r)));

            // R7
            toggle_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (!evt && !soft_clr) |=> $stable(q_r));
        end else begin : g_lat
            always_ff @(posedge clk) begin
                if (rst || soft_clr) q_r <= 1'b0;
                else if (evt)        q_r <= 1'b1;
                else if (rd_clr)     q_r <= 1'b0;
            end

            // R8
            set_wins_chk: assert property (@(posedge clk) disable iff (rst)
                (evt && !soft_clr) |=> q_r);

            // R8
            rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
                (rd_clr && !evt && !soft_clr) |=> !q_r);
        end
    endgenerate

    // R9
    soft_clr_chk: assert property (@(posedge clk) disable iff (rst)
        soft_clr |=> !q_r);

    assign q = q_r;
endmodule

// File: rtl/fdcs_fmt.sv
module fdcs_fmt
    import fdcs_pkg::*;
(
    input  fmode_e      mode,
    input  ctl_t        ctl,
    input  drv_t        drv,
    input  lat_t        lat,
    output logic [7:0]  reg_a,
    output logic [7:0]  reg_b,
    output logic        oe
);
    always_comb begin
        reg_a = 8'h00;
        reg_b = 8'h00;
        oe    = 1'b0;
        unique case (mode)
            FMODE_PS2: begin
                reg_a = fmt_a_ps2(ctl, drv);
                reg_b = fmt_b_ps2(ctl, lat);
                oe    = 1'b1;
            end
            FMODE_M30: begin
                reg_a = fmt_a_m30(ctl, drv, lat);
                reg_b = fmt_b_m30(ctl, lat);
                oe    = 1'b1;
            end
            default: begin
                reg_a = 8'h00;
                reg_b = 8'h00;
                oe    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fdc_drive_status.sv
module fdc_drive_status
    import fdcs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       soft_rst,
    input  logic [1:0] mode_sel,
    input  logic       dir_rd,
    input  logic       ctl_dir,
    input  logic       ctl_head,
    input  logic       ctl_step,
    input  logic       ctl_wgate,
    input  logic       ctl_wdata,
    input  logic       irq_pend,
    input  logic       dma_pend,
    input  logic [1:0] motor_en,
    input  logic [1:0] drv_sel,
    input  logic       pin_wprot,
    input  logic       pin_index,
    input  logic       pin_trk0,
    input  logic       pin_rdata,
    output logic [7:0] stat_a,
    output logic [7:0] stat_b,
    output logic       stat_oe
);
    ctl_t ctl_i, ctl_q;
    drv_t drv_raw, drv_s;
    logic [DRV_W-1:0] drv_s_bits;
    logic rd_prev;
    logic [NEV-1:0] evt, lat_bits;
    lat_t lat;

    assign ctl_i.dir   = ctl_dir;
    assign ctl_i.head  = ctl_head;
    assign ctl_i.step  = ctl_step;
    assign ctl_i.wgate = ctl_wgate;
    assign ctl_i.wdata = ctl_wdata;
    assign ctl_i.irq   = irq_pend;
    assign ctl_i.dma   = dma_pend;
    assign ctl_i.mtr   = motor_en;
    assign ctl_i.sel   = drv_sel;

    assign drv_raw.wp    = pin_wprot;
    assign drv_raw.index = pin_index;
    assign drv_raw.trk0  = pin_trk0;
    assign drv_raw.rdata = pin_rdata;

    // controller copy: cleared only by the hardware reset
    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_i;
    end

    fdcs_sync #(.W(DRV_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (drv_raw),
        .q   (drv_s_bits)
    );
    assign drv_s = drv_t'(drv_s_bits);

    always_ff @(posedge clk) begin
        if (rst) rd_prev <= 1'b0;
        else     rd_prev <= drv_s.rdata;
    end

    // one-clock edge pulses
    assign evt[EV_STEP]   = ctl_i.step  & ~ctl_q.step;
    assign evt[EV_WGATE]  = ctl_i.wgate & ~ctl_q.wgate;
    assign evt[EV_RDATA]  = rd_prev     & ~drv_s.rdata;
    assign evt[EV_WDATA]  = ctl_q.wdata & ~ctl_i.wdata;
    assign evt[EV_RD_TOG] = evt[EV_RDATA];
    assign evt[EV_WD_TOG] = evt[EV_WDATA];

    genvar g;
    generate
        for (g = 0; g < NEV; g++) begin : g_cell
            fdcs_event_cell #(.IS_TOGGLE(TOG_MASK[g])) u_cell (
                .clk      (clk),
                .rst      (rst),
                .soft_clr (soft_rst),
                .rd_clr   (dir_rd & ~TOG_MASK[g]),
                .evt      (evt[g]),
                .q        (lat_bits[g])
            );
        end
    endgenerate
    assign lat = lat_t'(lat_bits);

    fdcs_fmt u_fmt (
        .mode  (fmode_e'(mode_sel)),
        .ctl   (ctl_q),
        .drv   (drv_s),
        .lat   (lat),
        .reg_a (stat_a),
        .reg_b (stat_b),
        .oe    (stat_oe)
    );

    // R1
    at_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b00 || mode_sel == 2'b11) |->
            (!stat_oe && stat_a == 8'h00 && stat_b == 8'h00));

    // R9
    soft_keeps_motor_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (ctl_q.mtr == $past(motor_en) && ctl_q.sel == $past(drv_sel)));
endmodule

// File: tb/tb_fdc_drive_status.sv
module tb_fdc_drive_status;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst, soft_rst, dir_rd;
    logic [1:0] mode_sel;
    logic ctl_dir, ctl_head, ctl_step, ctl_wgate, ctl_wdata, irq_pend, dma_pend;
    logic [1:0] motor_en, drv_sel;
    logic pin_wprot, pin_index, pin_trk0, pin_rdata;
    logic [7:0] stat_a, stat_b;
    logic stat_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fdc_drive_status dut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .mode_sel(mode_sel),
        .dir_rd(dir_rd), .ctl_dir(ctl_dir), .ctl_head(ctl_head),
        .ctl_step(ctl_step), .ctl_wgate(ctl_wgate), .ctl_wdata(ctl_wdata),
        .irq_pend(irq_pend), .dma_pend(dma_pend), .motor_en(motor_en),
        .drv_sel(drv_sel), .pin_wprot(pin_wprot), .pin_index(pin_index),
        .pin_trk0(pin_trk0), .pin_rdata(pin_rdata),
        .stat_a(stat_a), .stat_b(stat_b), .stat_oe(stat_oe)
    );

    // stimulus word: 0 dir,1 head,2 step,3 wgate,4 wdata,5 irq,6 dma,
    // 7 mtr0,8 mtr1,9 sel0,10 sel1,11 wp,12 index,13 trk0,14 rdata
    typedef struct packed {
        logic [1:0]  mode;
        logic [14:0] ins;
        logic [7:0]  ea;
        logic [7:0]  eb;
        logic        eo;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'b01, 15'h0000, 8'h56, 8'hC0, 1'b1},
        '{2'b01, 15'h0823, 8'hDD, 8'hC0, 1'b1},
        '{2'b01, 15'h328C, 8'h62, 8'hE5, 1'b1},
        '{2'b10, 15'h0000, 8'h29, 8'hC7, 1'b1},
        '{2'b10, 15'h4250, 8'h69, 8'hA7, 1'b1},
        '{2'b10, 15'h0000, 8'h29, 8'hDF, 1'b1},
        '{2'b01, 15'h0000, 8'h56, 8'hD8, 1'b1},
        '{2'b00, 15'h0021, 8'h00, 8'h00, 1'b0},
        '{2'b11, 15'h0000, 8'h00, 8'h00, 1'b0},
        '{2'b01, 15'h4000, 8'h56, 8'hD8, 1'b1},
        '{2'b01, 15'h0000, 8'h56, 8'hD0, 1'b1}
    };
    localparam string VTAG [NV] = '{
        "R2 R4 R10", "R2", "R2 R4 R6", "R3 R5 R6", "R3 R5",
        "R5 R6 R7", "R4 R7", "R1", "R1", "R4 R7", "R4 R7"
    };

    task automatic set_ins(input logic [1:0] m, input logic [14:0] w);
        mode_sel  = m;
        ctl_dir   = w[0];  ctl_head = w[1];  ctl_step  = w[2];
        ctl_wgate = w[3];  ctl_wdata = w[4]; irq_pend  = w[5];
        dma_pend  = w[6];  motor_en = w[8:7]; drv_sel  = w[10:9];
        pin_wprot = w[11]; pin_index = w[12]; pin_trk0 = w[13];
        pin_rdata = w[14];
    endtask

    task automatic chk(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
        end
    endtask

    task automatic step_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; soft_rst = 1'b0; dir_rd = 1'b0;
        set_ins(2'b01, 15'h0000);
        step_clk(3);
        // R10 reset state
        chk("R10", "reset stat_a", stat_a, 8'h56);
        chk("R10", "reset stat_b", stat_b, 8'hC0);
        chk("R10", "reset stat_oe", {7'd0, stat_oe}, 8'h01);
        rst = 1'b0;
        step_clk(2);

        for (int i = 0; i < NV; i++) begin
            set_ins(VECS[i].mode, VECS[i].ins);
            step_clk(4);
            chk(VTAG[i], "stat_a", stat_a, VECS[i].ea);
            chk(VTAG[i], "stat_b", stat_b, VECS[i].eb);
            chk(VTAG[i], "stat_oe", {7'd0, stat_oe}, {7'd0, VECS[i].eo});
        end

        // R8: read of the digital input register clears the flags
        set_ins(2'b10, 15'h0000);
        dir_rd = 1'b1; step_clk(1); dir_rd = 1'b0; step_clk(1);
        chk("R8", "m30 stat_a after clear", stat_a, 8'h09);
        chk("R8", "m30 stat_b after clear", stat_b, 8'hC3);
        mode_sel = 2'b01; step_clk(1);
        chk("R7", "toggles survive dir_rd", stat_b, 8'hD0);

        // R8: set edge and clearing read in one clock, set wins
        mode_sel = 2'b10;
        ctl_step = 1'b1; dir_rd = 1'b1; step_clk(1);
        dir_rd = 1'b0; step_clk(1);
        chk("R8", "step set beats clear", stat_a, 8'h29);
        // R6: held level does not re-set after a clear
        dir_rd = 1'b1; step_clk(1); dir_rd = 1'b0; step_clk(1);
        chk("R6", "held step no re-set", stat_a, 8'h09);

        // R9: soft reset clears flags/toggles, keeps motor and select
        set_ins(2'b01, 15'h0000); step_clk(2);
        set_ins(2'b01, 15'h0384); step_clk(4);
        chk("R4", "motor/select levels", stat_b, 8'hF3);
        chk("R2", "step level", stat_a, 8'h76);
        soft_rst = 1'b1; step_clk(1);
        chk("R9", "soft reset keeps motor", stat_b, 8'hE3);
        soft_rst = 1'b0;
        mode_sel = 2'b10; step_clk(1);
        chk("R9", "soft reset clears step flag", stat_a, 8'h09);
        chk("R9", "soft reset clears m30 flags", stat_b, 8'hA3);

        // R10: hardware reset clears motor and select copies
        mode_sel = 2'b01;
        rst = 1'b1; step_clk(1);
        chk("R10", "hard reset stat_b", stat_b, 8'hC0);
        chk("R10", "hard reset stat_a", stat_a, 8'h56);
        rst = 1'b0; step_clk(3);
        chk("R4", "levels return after reset", stat_b, 8'hE3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule